// File: doc/BRIEF.md
# Host Bus Register Interface with Wait-States

This block connects a host processor that uses asynchronous strobes to a clocked design. The host selects the block with an active-low chip select and marks a valid address with an active-low address strobe. A write-enable level gives the direction, a 4-bit address picks the target, and a 16-bit data path carries the value. The block samples the strobes on the system clock. It counts rising edges from the first edge at which both strobes are seen low, and it answers with a READY handshake that holds the host in wait states for as long as the target needs.

The most significant address bit splits the address space into two parts. When it is zero, the access goes to three local registers: control at index 0, status at index 1 and op-code at index 2. When it is one, the access goes to a forwarded register port. That port is modelled here by an eight-entry register file. During a forwarded access the block also drives an active-low write strobe toward that port.

The number of wait states depends on both the target and the direction. A local write waits one cycle. A local read waits none. A forwarded write waits three cycles and a forwarded read waits five. After each access the block waits until the strobes are released before it accepts a new one.

Top module: `hostbus_waitstate_if`

## Requirements
- R1: An access starts only at a rising clock edge where `as_n` and `cs_n` are both sampled low. With `as_n` low and `cs_n` high, `ready` stays high and no register changes.
- R2: The address is captured at the clock edge where `as_n` is first sampled low. Changes on `addr` after that edge do not redirect the access.
- R3: With `we_n` low the access writes `data_i` into the addressed register. With `we_n` high it reads that register onto `data_o`.
- R4: On a local write (`addr[3]`=0), `ready` is low after the first edge (E1) only and is high again after E2. `data_i` is stored at E2. Local indices 3 to 7 ignore writes.
- R5: On a local read, `ready` never goes low. From E2 onward, `data_o` carries the addressed register (control=0, status=1, op-code=2). Indices 3 to 7 read as zero.
- R6: On a forwarded write (`addr[3]`=1), `ready` is low after E1, E2 and E3 and returns high at E4. The value lands in forwarded entry `addr[2:0]`.
- R7: On a forwarded read, `ready` is low after E1 through E5 and returns high at E6. `data_o` carries forwarded entry `addr[2:0]` from E2 onward.
- R8: `data_oe` is low whenever `cs_n` is high, during any write, before E2 of a read, and once the strobes are released.
- R9: `fwd_we_n` follows the host write direction only while a forwarded access is waiting. It is low during a forwarded write's wait states and high at all other times.
- R10: Synchronous active-low `rst_n` clears all local and forwarded registers, sets `ready` high and `data_oe` low. After reset, strobes that were held low start nothing until they are released and asserted again.
- R11: `addr[3]` selects the target space, so the same low index in the two spaces names two separate registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Active-low address strobe |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Direction: low = write, high = read |
| addr | input | 4 | Bit 3 selects the space, bits 2..0 give the index |
| data_i | input | 16 | Write data from the host |
| data_o | output | 16 | Read data toward the host |
| data_oe | output | 1 | Output-enable for the host data bus driver |
| ready | output | 1 | Handshake, low while the host must wait |
| fwd_we_n | output | 1 | Active-low write strobe toward the forwarded port |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, a 4-bit address, three local registers, an eight-entry forwarded file and wait lengths of 1, 3 and 5 cycles. With these values every index in both spaces is reached, including the five unmapped local indices. Random accesses mix both directions and both spaces, and each one is sampled for eight cycles. This lets the bench count the exact number of wait states, the first cycle of bus drive and the write-strobe level for every combination of target and direction. Directed cases cover chip select held high, an address that changes after the strobe edge, and strobes held low across reset.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } hbw_state_e;

endpackage

// File: rtl/hbw_regfile.sv
module hbw_regfile #(
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 3,
    parameter int NUM_REGS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q)); // R3

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) >= NUM_REGS)) |=> $stable(regs_q)); // R4

endmodule

// File: rtl/hbw_seq.sv
module hbw_seq
    import hbw_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int INT_WR_WAIT = 1,
    parameter int FWD_WR_WAIT = 3,
    parameter int FWD_RD_WAIT = 5,
    localparam int MAX_WAIT   = (FWD_RD_WAIT > FWD_WR_WAIT) ? FWD_RD_WAIT : FWD_WR_WAIT,
    localparam int CNT_W      = $clog2(MAX_WAIT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_fwd,
    output logic              wr_local_now,
    output logic              wr_fwd_now,
    output logic              drive,
    output logic              ready,
    output logic              fwd_we_n
);

    typedef struct packed {
        hbw_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              as_prev;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              fwd;
        logic              ready;
        logic              drive;
    } seq_t;

    seq_t q, d;

    logic              strobes_on;
    logic              as_fell;
    logic [ADDR_W-1:0] addr_eff;
    logic [CNT_W-1:0]  wait_len;
    logic              last_edge;

    always_comb begin
        strobes_on = !as_n && !cs_n;
        as_fell    = q.as_prev && !as_n;
        addr_eff   = as_fell ? addr : q.addr;

        if (q.fwd) begin
            wait_len = q.wr ? CNT_W'(FWD_WR_WAIT) : CNT_W'(FWD_RD_WAIT);
        end else begin
            wait_len = q.wr ? CNT_W'(INT_WR_WAIT) : CNT_W'(1);
        end
        last_edge = (q.state == ST_BUSY) && strobes_on && (q.cnt == wait_len);

        d         = q;
        d.as_prev = as_n;
        if (as_fell) begin
            d.addr = addr;
        end

        unique case (q.state)
            ST_IDLE: begin
                d.drive = 1'b0;
                d.ready = 1'b1;
                if (strobes_on) begin
                    d.state = ST_BUSY;
                    d.cnt   = CNT_W'(1);
                    d.addr  = addr_eff;
                    d.wr    = !we_n;
                    d.fwd   = addr_eff[ADDR_W-1];
                    d.ready = we_n && !addr_eff[ADDR_W-1];
                end
            end
            ST_BUSY: begin
                if (!strobes_on) begin
                    d.state = ST_IDLE;
                    d.ready = 1'b1;
                    d.drive = 1'b0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                    if (!q.wr && (q.cnt == CNT_W'(1))) begin
                        d.drive = 1'b1;
                    end
                    if (last_edge) begin
                        d.ready = 1'b1;
                        d.state = ST_HOLD;
                    end
                end
            end
            default: begin
                if (!strobes_on) begin
                    d.state = ST_IDLE;
                    d.ready = 1'b1;
                    d.drive = 1'b0;
                end
            end
        endcase

        wr_local_now = last_edge && q.wr && !q.fwd;
        wr_fwd_now   = last_edge && q.wr && q.fwd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_HOLD;
            q.cnt     <= '0;
            q.as_prev <= 1'b1;
            q.addr    <= '0;
            q.wr      <= 1'b0;
            q.fwd     <= 1'b0;
            q.ready   <= 1'b1;
            q.drive   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign acc_addr = q.addr;
    assign acc_fwd  = q.fwd;
    assign drive    = q.drive;
    assign ready    = q.ready;
    assign fwd_we_n = !((q.state == ST_BUSY) && q.fwd && q.wr);

    AST_START_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ready) |-> $past(!as_n && !cs_n)); // R1

    AST_LOCAL_WRITE_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_BUSY && q.wr && !q.fwd) |-> (q.cnt == CNT_W'(INT_WR_WAIT))); // R4

    AST_LOCAL_READ_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_BUSY && !q.wr && !q.fwd) |-> q.ready); // R5

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_BUSY) |-> (q.cnt <= CNT_W'(MAX_WAIT))); // R7

    AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        q.drive |-> !q.wr); // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> (q.ready && !q.drive)); // R10

endmodule

// File: rtl/hostbus_waitstate_if.sv
module hostbus_waitstate_if #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int NUM_LOCAL   = 3,
    parameter int INT_WR_WAIT = 1,
    parameter int FWD_WR_WAIT = 3,
    parameter int FWD_RD_WAIT = 5,
    localparam int IDX_W      = ADDR_W - 1,
    localparam int NUM_FWD    = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic              ready,
    output logic              fwd_we_n
);

    logic [ADDR_W-1:0] acc_addr;
    logic              acc_fwd;
    logic              wr_local_now;
    logic              wr_fwd_now;
    logic              drive;
    logic [DATA_W-1:0] local_rd;
    logic [DATA_W-1:0] fwd_rd;

    hbw_seq #(
        .ADDR_W      (ADDR_W),
        .INT_WR_WAIT (INT_WR_WAIT),
        .FWD_WR_WAIT (FWD_WR_WAIT),
        .FWD_RD_WAIT (FWD_RD_WAIT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_n         (as_n),
        .cs_n         (cs_n),
        .we_n         (we_n),
        .addr         (addr),
        .acc_addr     (acc_addr),
        .acc_fwd      (acc_fwd),
        .wr_local_now (wr_local_now),
        .wr_fwd_now   (wr_fwd_now),
        .drive        (drive),
        .ready        (ready),
        .fwd_we_n     (fwd_we_n)
    );

    hbw_regfile #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_LOCAL)
    ) u_local (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_local_now),
        .wr_idx  (acc_addr[IDX_W-1:0]),
        .wr_data (data_i),
        .rd_idx  (acc_addr[IDX_W-1:0]),
        .rd_data (local_rd)
    );

    hbw_regfile #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_FWD)
    ) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fwd_now && !fwd_we_n),
        .wr_idx  (acc_addr[IDX_W-1:0]),
        .wr_data (data_i),
        .rd_idx  (acc_addr[IDX_W-1:0]),
        .rd_data (fwd_rd)
    );

    always_comb begin
        data_o  = '0;
        if (drive) begin
            data_o = acc_fwd ? fwd_rd : local_rd;
        end
        data_oe = drive && !cs_n;
    end

    AST_FWD_STROBE_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_we_n |-> !ready); // R9

    AST_LOCAL_WRITE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_local_now |-> fwd_we_n); // R11

endmodule

// File: tb/hostbus_waitstate_if_tb.sv
module hostbus_waitstate_if_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        we_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] data_i = '0;
    logic [15:0] data_o;
    logic        data_oe;
    logic        ready;
    logic        fwd_we_n;

    int checks = 0;
    int errors = 0;

    logic [15:0] loc_m [8];
    logic [15:0] fwd_m [8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    hostbus_waitstate_if u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n     (as_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .addr     (addr),
        .data_i   (data_i),
        .data_o   (data_o),
        .data_oe  (data_oe),
        .ready    (ready),
        .fwd_we_n (fwd_we_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_wait(input bit wr, input logic [3:0] a);
        if (a[3]) return wr ? 3 : 5;
        return wr ? 1 : 0;
    endfunction

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        if (a[3]) return fwd_m[a[2:0]];
        if (a[2:0] < 3) return loc_m[a[2:0]];
        return 16'h0;
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [15:0] v);
        if (a[3]) fwd_m[a[2:0]] = v;
        else if (a[2:0] < 3) loc_m[a[2:0]] = v;
    endtask

    task automatic clear_model();
        for (int i = 0; i < 8; i++) begin
            loc_m[i] = '0;
            fwd_m[i] = '0;
        end
    endtask

    task automatic release_bus();
        as_n = 1'b1;
        cs_n = 1'b1;
        @(negedge clk);
        chk("R8 oe after release", {31'b0, data_oe}, 32'd0);
        chk("R1 ready idle", {31'b0, ready}, 32'd1);
    endtask

    task automatic do_acc(input bit wr, input logic [3:0] a, input logic [15:0] wd);
        int lows;
        logic [15:0] expd;
        lows = 0;
        expd = exp_read(a);
        @(negedge clk);
        addr = a; we_n = !wr; data_i = wd; as_n = 1'b0; cs_n = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (!ready) lows++;
            if (k == 1) begin
                chk("R8 no drive before E2", {31'b0, data_oe}, 32'd0);
                chk("R9 fwd strobe", {31'b0, fwd_we_n}, {31'b0, !(a[3] && wr)});
            end
            if (k == 2) begin
                if (wr) begin
                    chk("R8 no drive on write", {31'b0, data_oe}, 32'd0);
                end else begin
                    chk("R5/R7 oe from E2", {31'b0, data_oe}, 32'd1);
                    chk(a[3] ? "R7 fwd read data" : "R5 local read data",
                        {16'b0, data_o}, {16'b0, expd});
                end
            end
            if (k == 7) chk("R9 strobe released", {31'b0, fwd_we_n}, 32'd1);
        end
        if (a[3]) chk(wr ? "R6 fwd write wait" : "R7 fwd read wait", lows, exp_wait(wr, a));
        else      chk(wr ? "R4 local write wait" : "R5 local read wait", lows, exp_wait(wr, a));
        if (wr) model_write(a, wd);
        release_bus();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h1234_5eed));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", {31'b0, ready}, 32'd1);
        chk("R10 reset oe", {31'b0, data_oe}, 32'd0);
        chk("R10 reset strobe", {31'b0, fwd_we_n}, 32'd1);

        // R11: same index in both spaces is distinct
        do_acc(1'b1, 4'h1, 16'hAAAA);
        do_acc(1'b1, 4'h9, 16'h5555);
        do_acc(1'b0, 4'h1, 16'h0);
        do_acc(1'b0, 4'h9, 16'h0);
        chk("R11 local kept", {16'b0, loc_m[1]}, 32'hAAAA);

        // R4/R5: unmapped local index ignores writes, reads zero
        do_acc(1'b1, 4'h5, 16'hBEEF);
        do_acc(1'b0, 4'h5, 16'h0);

        // R1: chip select high blocks the access
        @(negedge clk);
        addr = 4'h0; we_n = 1'b0; data_i = 16'hDEAD; as_n = 1'b0; cs_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R1 ready while cs high", {31'b0, ready}, 32'd1);
        end
        as_n = 1'b1;
        @(negedge clk);
        do_acc(1'b0, 4'h0, 16'h0);

        // R2: address latched at strobe edge
        @(negedge clk);
        addr = 4'h2; we_n = 1'b0; data_i = 16'h7777; as_n = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        addr = 4'h1;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        loc_m[2] = 16'h7777;
        release_bus();
        do_acc(1'b0, 4'h2, 16'h0);
        do_acc(1'b0, 4'h1, 16'h0);
        chk("R2 latched address", {16'b0, loc_m[2]}, 32'h7777);

        // random mix
        for (int n = 0; n < 80; n++) begin
            v = 16'($urandom);
            do_acc(1'($urandom), 4'($urandom), v);
        end

        // R10: strobes held low across reset start nothing
        @(negedge clk);
        addr = 4'h0; we_n = 1'b0; data_i = 16'h1111; as_n = 1'b0; cs_n = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R10 held strobes after reset", {31'b0, ready}, 32'd1);
        end
        release_bus();
        for (int i = 0; i < 16; i++) begin
            do_acc(1'b0, 4'(i), 16'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule